// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two component predictors and picks between them, branch by branch. The first component is indexed by a hash of recent global outcomes and the branch address. The second is indexed by the branch address alone. A third table, also addressed by the branch address, records which component has recently been the more reliable one for that branch and steers the output.

The fetch side presents a branch address and reads the taken bit back in the same cycle, through combinational logic. The resolve side presents a branch address and its real outcome on a single-cycle update strobe. At the clock edge both component tables train, the selector trains when the components disagreed about the outcome, and the global history then takes in the new outcome. The history does not advance speculatively, so a prediction and the update for the same branch index with the same history value when no other update falls between them.

Top module: `branch_dir_predictor`

## Requirements
- R1: After reset every counter in all three tables holds 01 and the global history is all zeros, so `predTaken` is 0 for any address.
- R2: A 2-bit counter votes taken when its upper bit is 1 (states 10 and 11) and not-taken when it holds 00 or 01.
- R3: On an update, a taken outcome moves the addressed counter up by one and a not-taken outcome moves it down by one, stopping at 11 and at 00.
- R4: Each update shifts the global history left by one and places the outcome (1 = taken) in bit 0. With `updValid` low the history holds its value.
- R5: The history-hashed table is addressed by address bits [GS_IDX_W+1:2] XOR the history, where the history is zero-extended to GS_IDX_W bits.
- R6: The address-only table is addressed by address bits [BM_IDX_W+1:2]. The selector table is addressed by address bits [CH_IDX_W+1:2]. Address bits 1:0 play no part in any index.
- R7: `predTaken` gives the history-hashed table's vote when the addressed selector counter is 10 or 11, and the address-only table's vote otherwise.
- R8: On an update the selector counter moves up when the history-hashed vote matched the outcome and the address-only vote did not. It moves down in the opposite case. It stays where it is when both votes were right or both were wrong.
- R9: Every update trains both component tables. The history-hashed table is written at the index formed from the history as it stood before that update's shift.
- R10: With `updValid` low, no table entry and no history bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| predPc | input | PC_W | Address of the branch being predicted |
| predTaken | output | 1 | Predicted direction for `predPc`, 1 = taken (combinational) |
| updValid | input | 1 | Update strobe for one resolved branch |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Real outcome of the resolved branch, 1 = taken |

## Verification
On every cycle the assertions check the following: counters only move in the direction of the outcome, the history takes in the outcome at bit 0 and holds without an update, the selector never moves when the two components agreed, and an idle cycle writes nothing. Other behaviour appears only through the bench's scenarios. This covers the chooser steering between components, aliasing between addresses that share index bits, saturation after long runs of one outcome, and the pre-shift history selecting the trained entry. The bench compares each prediction against a reference model of the tables and history.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_INIT = 2'b01;

  // Strobes from control to datapath for one update cycle
  typedef struct packed {
    logic gsWe;
    logic gsUp;
    logic bmWe;
    logic bmUp;
    logic chWe;
    logic chUp;
    logic histWe;
    logic histBit;
  } bp_strobe_t;

  // Saturating step of a 2-bit counter
  function automatic ctr2_t ctrStep(ctr2_t c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    else    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  function automatic logic ctrVote(ctr2_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rdIdx,
  output ctr2_t            rdCtr,
  input  logic [IDX_W-1:0] updIdx,
  output ctr2_t            updCtr,
  input  logic             wrEn,
  input  logic             wrUp
);

  localparam int DEPTH = 1 << IDX_W;

  ctr2_t cells [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= CTR_INIT;
    end else if (wrEn) begin
      cells[updIdx] <= ctrStep(cells[updIdx], wrUp);
    end
  end

  assign rdCtr  = cells[rdIdx];
  assign updCtr = cells[updIdx];

  // R3: a taken-direction write never lowers the entry
  a_r3_up_not_lower: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrUp |=> cells[$past(updIdx)] >= $past(updCtr));

  // R3: a not-taken-direction write never raises the entry
  a_r3_down_not_higher: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !wrUp |=> cells[$past(updIdx)] <= $past(updCtr));

  // R10: no write strobe, the update-side entry keeps its value
  a_r10_entry_stable: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> cells[$past(updIdx)] == $past(updCtr));

endmodule

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int HIST_W   = 8,
  parameter int GS_IDX_W = 8,
  parameter int BM_IDX_W = 8,
  parameter int CH_IDX_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] predPc,
  input  logic [PC_W-1:0] updPc,
  input  bp_strobe_t      strb,
  output ctr2_t           predGs,
  output ctr2_t           predBm,
  output ctr2_t           predCh,
  output ctr2_t           updGs,
  output ctr2_t           updBm,
  output ctr2_t           updCh,
  output logic [HIST_W-1:0] histOut
);

  localparam int PC_LSB = 2;

  logic [HIST_W-1:0]   ghr;
  logic [GS_IDX_W-1:0] histExt;
  logic [GS_IDX_W-1:0] gsPredIdx, gsUpdIdx;
  logic [BM_IDX_W-1:0] bmPredIdx, bmUpdIdx;
  logic [CH_IDX_W-1:0] chPredIdx, chUpdIdx;

  // History fitted to the hashed index width
  generate
    if (HIST_W >= GS_IDX_W) begin : g_histTrunc
      assign histExt = ghr[GS_IDX_W-1:0];
    end else begin : g_histExtend
      assign histExt = {{(GS_IDX_W-HIST_W){1'b0}}, ghr};
    end
  endgenerate

  assign gsPredIdx = predPc[GS_IDX_W+PC_LSB-1:PC_LSB] ^ histExt;
  assign gsUpdIdx  = updPc[GS_IDX_W+PC_LSB-1:PC_LSB]  ^ histExt;
  assign bmPredIdx = predPc[BM_IDX_W+PC_LSB-1:PC_LSB];
  assign bmUpdIdx  = updPc[BM_IDX_W+PC_LSB-1:PC_LSB];
  assign chPredIdx = predPc[CH_IDX_W+PC_LSB-1:PC_LSB];
  assign chUpdIdx  = updPc[CH_IDX_W+PC_LSB-1:PC_LSB];

  // Table update uses the current history; the shift lands at the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ghr <= '0;
    else if (strb.histWe) begin
      if (HIST_W > 1) ghr <= {ghr[HIST_W-2:0], strb.histBit};
      else            ghr <= HIST_W'(strb.histBit);
    end
  end

  assign histOut = ghr;

  bp_ctr_table #(.IDX_W(GS_IDX_W)) uGsTable (
    .clk(clk), .rstN(rstN),
    .rdIdx(gsPredIdx), .rdCtr(predGs),
    .updIdx(gsUpdIdx), .updCtr(updGs),
    .wrEn(strb.gsWe), .wrUp(strb.gsUp)
  );

  bp_ctr_table #(.IDX_W(BM_IDX_W)) uBmTable (
    .clk(clk), .rstN(rstN),
    .rdIdx(bmPredIdx), .rdCtr(predBm),
    .updIdx(bmUpdIdx), .updCtr(updBm),
    .wrEn(strb.bmWe), .wrUp(strb.bmUp)
  );

  bp_ctr_table #(.IDX_W(CH_IDX_W)) uChTable (
    .clk(clk), .rstN(rstN),
    .rdIdx(chPredIdx), .rdCtr(predCh),
    .updIdx(chUpdIdx), .updCtr(updCh),
    .wrEn(strb.chWe), .wrUp(strb.chUp)
  );

endmodule

// File: rtl/bp_control.sv
module bp_control
  import bp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctr2_t      predGs,
  input  ctr2_t      predBm,
  input  ctr2_t      predCh,
  input  ctr2_t      updGs,
  input  ctr2_t      updBm,
  input  logic       updValid,
  input  logic       updTaken,
  output logic       predTaken,
  output bp_strobe_t strb
);

  logic useGs;
  logic gsRight, bmRight;

  // Selection: upper chooser bit picks the history-hashed vote
  assign useGs     = ctrVote(predCh);
  assign predTaken = useGs ? ctrVote(predGs) : ctrVote(predBm);

  assign gsRight = (ctrVote(updGs) == updTaken);
  assign bmRight = (ctrVote(updBm) == updTaken);

  always_comb begin
    strb         = '0;
    strb.gsWe    = updValid;
    strb.gsUp    = updTaken;
    strb.bmWe    = updValid;
    strb.bmUp    = updTaken;
    strb.chWe    = updValid && (gsRight != bmRight);
    strb.chUp    = gsRight;
    strb.histWe  = updValid;
    strb.histBit = updTaken;
  end

  // R8: components that voted alike leave the chooser alone
  a_r8_agree_no_move: assert property (@(posedge clk) disable iff (!rstN)
    updValid && (updGs[1] == updBm[1]) |-> !strb.chWe);

  // R9: every update trains both components
  a_r9_both_trained: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> strb.gsWe && strb.bmWe && strb.histWe);

  // R10: an idle cycle raises no write strobe
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |-> !(strb.gsWe || strb.bmWe || strb.chWe || strb.histWe));

endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor
  import bp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int HIST_W   = 8,
  parameter int GS_IDX_W = 8,
  parameter int BM_IDX_W = 8,
  parameter int CH_IDX_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] predPc,
  output logic            predTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);

  bp_strobe_t        strb;
  ctr2_t             predGs, predBm, predCh;
  ctr2_t             updGs, updBm, updCh;
  logic [HIST_W-1:0] hist;

  bp_datapath #(
    .PC_W(PC_W), .HIST_W(HIST_W), .GS_IDX_W(GS_IDX_W),
    .BM_IDX_W(BM_IDX_W), .CH_IDX_W(CH_IDX_W)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .predPc(predPc), .updPc(updPc), .strb(strb),
    .predGs(predGs), .predBm(predBm), .predCh(predCh),
    .updGs(updGs), .updBm(updBm), .updCh(updCh),
    .histOut(hist)
  );

  bp_control uCtl (
    .clk(clk), .rstN(rstN),
    .predGs(predGs), .predBm(predBm), .predCh(predCh),
    .updGs(updGs), .updBm(updBm),
    .updValid(updValid), .updTaken(updTaken),
    .predTaken(predTaken), .strb(strb)
  );

  // R4: the resolved outcome enters the history at bit 0
  a_r4_outcome_at_lsb: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> hist[0] == $past(updTaken));

  // R4: without an update the history holds
  a_r4_hist_holds: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(hist));

  // R8: the selector entry of an update stays put when votes agreed
  a_r8_chooser_stable: assert property (@(posedge clk) disable iff (!rstN)
    updValid && (updGs[1] == updBm[1]) |=> uDp.uChTable.cells[$past(updPc[CH_IDX_W+1:2])] == $past(updCh));

endmodule

// File: tb/branch_dir_predictor_test.sv
module branch_dir_predictor_test;

  localparam int PC_W = 32;
  localparam int HW   = 8;
  localparam int IW   = 8;
  localparam int N    = 1 << IW;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [PC_W-1:0] predPc = '0;
  logic            predTaken;
  logic            updValid = 1'b0;
  logic [PC_W-1:0] updPc = '0;
  logic            updTaken = 1'b0;

  int vectors = 0;
  int miscompares = 0;

  // Reference state
  logic [1:0]    mGs [N];
  logic [1:0]    mBm [N];
  logic [1:0]    mCh [N];
  logic [HW-1:0] mHist;

  always #5 clk = ~clk;

  branch_dir_predictor uut (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predTaken(predTaken),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken)
  );

  function automatic logic [IW-1:0] pcIdx(logic [PC_W-1:0] pc);
    return pc[IW+1:2];
  endfunction

  function automatic logic [1:0] sat(logic [1:0] c, logic up);
    if (up) return (c == 2'b11) ? 2'b11 : c + 2'd1;
    return (c == 2'b00) ? 2'b00 : c - 2'd1;
  endfunction

  function automatic logic modelPredict(logic [PC_W-1:0] pc);
    logic [IW-1:0] gi;
    gi = pcIdx(pc) ^ mHist;
    return mCh[pcIdx(pc)][1] ? mGs[gi][1] : mBm[pcIdx(pc)][1];
  endfunction

  task automatic modelReset();
    for (int i = 0; i < N; i++) begin
      mGs[i] = 2'b01; mBm[i] = 2'b01; mCh[i] = 2'b01;
    end
    mHist = '0;
  endtask

  task automatic modelUpdate(logic [PC_W-1:0] pc, logic t);
    logic [IW-1:0] gi, ai;
    logic gr, br;
    ai = pcIdx(pc);
    gi = ai ^ mHist;
    gr = (mGs[gi][1] == t);
    br = (mBm[ai][1] == t);
    if (gr != br) mCh[ai] = sat(mCh[ai], gr);
    mGs[gi] = sat(mGs[gi], t);
    mBm[ai] = sat(mBm[ai], t);
    mHist   = {mHist[HW-2:0], t};
  endtask

  task automatic check(string tag, logic got, logic exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: predTaken=%0b expected %0b (pc=%h)", tag, got, exp, predPc);
    end
  endtask

  // One cycle: present a prediction address and optional update,
  // check the combinational prediction, then let the edge apply the update.
  task automatic step(string tag, logic [PC_W-1:0] pp, logic v,
                      logic [PC_W-1:0] up, logic t);
    @(negedge clk);
    predPc = pp; updValid = v; updPc = up; updTaken = t;
    #1;
    check(tag, predTaken, modelPredict(pp));
    @(posedge clk);
    if (v) modelUpdate(up, t);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; updValid = 1'b0;
    modelReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] pc;
    logic t;
    void'($urandom(32'd20240611));
    doReset();

    // R1: reset state predicts not-taken everywhere
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      predPc = 32'h0000_0100 + 32'(k * 68);
      #1;
      check("R1 reset", predTaken, 1'b0);
    end

    // R7/R2: one taken update makes the bimodal entry 10, chooser still 01
    step("R3 first taken", 32'h100, 1'b1, 32'h100, 1'b1);
    @(negedge clk); updValid = 1'b0; predPc = 32'h100; #1;
    check("R7 bimodal selected", predTaken, 1'b1);
    // R8: not-taken, gshare right (index 0x41 at 01), bimodal wrong -> chooser 10
    step("R8 disagree", 32'h100, 1'b1, 32'h100, 1'b0);
    @(negedge clk); updValid = 1'b0; predPc = 32'h100; #1;
    check("R7 gshare selected", predTaken, 1'b0);
    // R6: low two address bits ignored
    @(negedge clk); predPc = 32'h103; #1;
    check("R6 low bits ignored", predTaken, 1'b0);
    // R10: idle cycles change nothing
    for (int k = 0; k < 3; k++) step("R10 idle", 32'h100, 1'b0, 32'h100, 1'b1);
    check("R10 after idle", predTaken, 1'b0);

    // R3: saturation with a long taken run on one branch, then long not-taken
    for (int k = 0; k < 12; k++) step("R3 saturate up", 32'h240, 1'b1, 32'h240, 1'b1);
    for (int k = 0; k < 12; k++) step("R3 saturate down", 32'h240, 1'b1, 32'h240, 1'b0);

    // R4/R9: toggle branch, trained through history
    for (int k = 0; k < 40; k++) step("R4 R9 toggle", 32'h380, 1'b1, 32'h380, 1'(k & 1));

    // R5: aliased addresses sharing index bits
    for (int k = 0; k < 30; k++) begin
      pc = (k & 1) ? 32'h0000_0500 : 32'h0001_0500;
      step("R5 alias", pc, 1'b1, pc, 1'(k % 3 != 0));
    end

    doReset();
    step("R1 re-reset", 32'h240, 1'b0, 32'h0, 1'b0);

    // Random mix for R2, R5, R6, R7, R8, R9
    for (int k = 0; k < 4000; k++) begin
      pc = 32'h1000 + 32'(($urandom % 24) * 4);
      if ($urandom % 8 == 0) pc = pc + 32'h400;
      t  = (pc[3] ^ pc[6]) ? ($urandom % 10 < 8) : ($urandom % 10 < 2);
      if (pc[4] && pc[2]) t = mHist[0] ^ 1'b1;
      step("R7 R8 random", 32'h1000 + 32'(($urandom % 24) * 4) + 32'($urandom % 4),
           ($urandom % 6) != 0, pc, t);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule